// File: doc/BRIEF.md
# Single-Wire Serial Identity Responder

This block is the device end of an open-drain single-wire bus on which a host reads a fixed 64-bit identity word. The bus level comes in on one input and passes through a two-flop synchroniser. The block pulls the line low through one output, and an external pull-up releases it. All bus timing is measured in clock ticks, scaled by a ticks-per-microsecond parameter.

The host starts each exchange with a long low pulse. The block answers it with a presence pulse. It then receives a one-byte command in write slots, where the width of each host low pulse encodes one bit. If the command asks for the identity, the block returns the 64-bit word one bit per host-initiated read slot, holding the line low to send a zero. The identity is a parameter. Its least significant byte is the family code, the next 48 bits are the serial number, and the top byte is the check byte, which is supplied with the word rather than computed.

Top module: `ow_id_responder`

## Requirements
- R1: While reset is applied and after it is released, `pull_low` is 0 until the bus shows activity.
- R2: A bus low pulse of at least RESET_US (480 µs) restarts the block from any state, including in the middle of a read-out, and a presence pulse follows.
- R3: A low pulse shorter than RESET_US while idle produces no presence pulse and does not arm the block. A command and read slots that follow get no response.
- R4: After a qualifying reset pulse is released, the line stays released for PRES_WAIT_US (30 µs) and is then pulled low for PRES_LEN_US (120 µs).
- R5: Command bits are sampled SAMPLE_US (30 µs) after each slot's falling edge, with low meaning 0 and high meaning 1. The first slot carries bit 0 (LSB first). A host low of 1–15 µs therefore reads as 1, and a host low of 60–120 µs reads as 0.
- R6: After command READ_CMD (0x33), the next 64 read slots return ID_WORD bit 0 first. Bit 0 is the LSB of the family byte and bit 63 is the MSB of the check byte.
- R7: In a read slot a 0 is sent by pulling the line low from the detected falling edge for DRIVE0_US (30 µs). A 1 leaves the line released.
- R8: Any other command (for example 0xCC or 0x32) leaves the block idle. Read slots until the next reset see the line released.
- R9: After the 64th identity bit the block is idle, and further read slots are not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Raw bus level (1 = released) |
| pull_low | output | 1 | 1 pulls the bus low (open-drain drive) |

## Verification
The bench builds the block with TICKS_PER_US = 2 and a non-default identity word whose bits mix ones and zeros, including a zero in bit 63. This keeps 480 µs resets and full 64-slot read-outs within a few tens of thousands of cycles while every microsecond still spans more than one tick. A behavioural model of the line predicts when the block should pull low and is compared with the output on every clock, outside a small guard band around each predicted edge. The command set is chosen so that the bit order (0xCC), a single decoded bit (0x32), a short reset and a reset during read-out are each reached.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PWAIT  = 3'd1,
        S_PDRIVE = 3'd2,
        S_CMD    = 3'd3,
        S_ROM    = 3'd4
    } ow_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ow_bus_sync.sv
module ow_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] sh_q, sh_d;
    logic              prev_q, prev_d;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], raw_in};
        prev_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign level = sh_q[STAGES-1];
    assign fall  = prev_q & ~level;
    assign rise  = ~prev_q & level;
endmodule

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
    parameter int LIMIT = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise,
    output logic rst_evt
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (level)
            cnt_d = '0;
        else if (cnt_q == CW'(LIMIT))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rst_evt = rise && (cnt_q >= CW'(LIMIT));
endmodule

// File: rtl/ow_id_responder.sv
module ow_id_responder
    import ow_pkg::*;
#(
    parameter int                  TICKS_PER_US = 50,
    parameter int                  ID_BITS      = 64,
    parameter int                  CMD_BITS     = 8,
    parameter logic [ID_BITS-1:0]  ID_WORD      = 64'hB4_0000_0001_0203_28,
    parameter logic [CMD_BITS-1:0] READ_CMD     = 8'h33,
    parameter int                  RESET_US     = 480,
    parameter int                  PRES_WAIT_US = 30,
    parameter int                  PRES_LEN_US  = 120,
    parameter int                  SAMPLE_US    = 30,
    parameter int                  DRIVE0_US    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic pull_low
);
    localparam int RESET_T = RESET_US * TICKS_PER_US;
    localparam int PWAIT_T = PRES_WAIT_US * TICKS_PER_US;
    localparam int PLEN_T  = PRES_LEN_US * TICKS_PER_US;
    localparam int SAMP_T  = SAMPLE_US * TICKS_PER_US;
    localparam int DRV_T   = DRIVE0_US * TICKS_PER_US;
    localparam int TMAX    = max2(max2(PWAIT_T, PLEN_T), max2(SAMP_T, DRV_T));
    localparam int TW      = $clog2(TMAX + 1);
    localparam int IW      = max2($clog2(ID_BITS), $clog2(CMD_BITS));

    typedef struct packed {
        ow_state_t           state;
        logic [TW-1:0]       tmr;
        logic [IW-1:0]       bit_cnt;
        logic [CMD_BITS-1:0] shreg;
        logic                busy;
        logic                pull;
    } resp_t;

    resp_t q, d;

    logic level, fall, rise, rst_evt;
    logic [CMD_BITS-1:0] cmd_next;

    ow_bus_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (bus_in),
        .level  (level),
        .fall   (fall),
        .rise   (rise)
    );

    ow_low_timer #(.LIMIT(RESET_T)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .rise    (rise),
        .rst_evt (rst_evt)
    );

    assign cmd_next = {level, q.shreg[CMD_BITS-1:1]};

    always_comb begin
        d = q;
        unique case (q.state)
            S_IDLE: ;
            S_PWAIT: begin
                d.tmr = q.tmr + TW'(1);
                if (q.tmr == TW'(PWAIT_T - 1)) begin
                    d.state = S_PDRIVE;
                    d.tmr   = '0;
                    d.pull  = 1'b1;
                end
            end
            S_PDRIVE: begin
                d.tmr = q.tmr + TW'(1);
                if (q.tmr == TW'(PLEN_T - 1)) begin
                    d.state   = S_CMD;
                    d.tmr     = '0;
                    d.pull    = 1'b0;
                    d.bit_cnt = '0;
                    d.busy    = 1'b0;
                end
            end
            S_CMD: begin
                if (!q.busy) begin
                    if (fall) begin
                        d.busy = 1'b1;
                        d.tmr  = '0;
                    end
                end else begin
                    d.tmr = q.tmr + TW'(1);
                    if (q.tmr == TW'(SAMP_T - 1)) begin
                        d.shreg   = cmd_next;
                        d.busy    = 1'b0;
                        d.bit_cnt = q.bit_cnt + IW'(1);
                        if (q.bit_cnt == IW'(CMD_BITS - 1)) begin
                            d.bit_cnt = '0;
                            d.state   = (cmd_next == READ_CMD) ? S_ROM : S_IDLE;
                        end
                    end
                end
            end
            S_ROM: begin
                if (!q.busy) begin
                    if (fall) begin
                        d.busy = 1'b1;
                        d.tmr  = '0;
                        d.pull = ~ID_WORD[q.bit_cnt];
                    end
                end else begin
                    d.tmr = q.tmr + TW'(1);
                    if (q.tmr == TW'(DRV_T - 1)) begin
                        d.pull    = 1'b0;
                        d.busy    = 1'b0;
                        d.bit_cnt = q.bit_cnt + IW'(1);
                        if (q.bit_cnt == IW'(ID_BITS - 1)) begin
                            d.bit_cnt = '0;
                            d.state   = S_IDLE;
                        end
                    end
                end
            end
            default: d.state = S_IDLE;
        endcase

        if (rst_evt) begin
            d.state   = S_PWAIT;
            d.tmr     = '0;
            d.bit_cnt = '0;
            d.busy    = 1'b0;
            d.pull    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= S_IDLE;
            q.tmr     <= '0;
            q.bit_cnt <= '0;
            q.shreg   <= '0;
            q.busy    <= 1'b0;
            q.pull    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pull_low = q.pull;

    ow_state_t state_w;
    assign state_w = q.state;
endmodule

// File: rtl/ow_id_checker.sv
module ow_id_checker
    import ow_pkg::*;
#(
    parameter int PLEN_T = 120
) (
    input logic      clk,
    input logic      rst_n,
    input logic      pull_low,
    input logic      fall,
    input logic      rst_evt,
    input ow_state_t state
);
    localparam int RW = $clog2(PLEN_T + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!pull_low)
            run_q <= '0;
        else if (run_q != '1)
            run_q <= run_q + RW'(1);
    end

    // R2
    reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (state == S_PWAIT));

    // R3
    presence_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PWAIT && $past(state) != S_PWAIT) |-> $past(rst_evt));

    // R4
    pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(PLEN_T));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !pull_low);

    // R7
    rom_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull_low) && state == S_ROM) |-> $past(fall));
endmodule

bind ow_id_responder ow_id_checker #(.PLEN_T(PLEN_T)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pull_low (pull_low),
    .fall     (fall),
    .rst_evt  (rst_evt),
    .state    (state_w)
);

// File: tb/tb_ow_id_responder.sv
module tb_ow_id_responder;
    localparam int          CLK_PERIOD = 10;
    localparam int          TPU        = 2;
    localparam logic [63:0] ID         = 64'h7E_5A3C0F9912C4_2D;
    localparam int          GUARD      = 5;
    localparam int          LAT        = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic bus;
    logic pull_low;

    assign bus = ~(host_low | pull_low);

    ow_id_responder #(
        .TICKS_PER_US (TPU),
        .ID_WORD      (ID)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus),
        .pull_low (pull_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int win_s[$];
    int win_e[$];
    bit model_fresh = 1'b0;
    bit model_armed = 1'b0;
    int model_idx = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model of the line, compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_pull;
            bit near;
            exp_pull = 1'b0;
            near = 1'b0;
            foreach (win_s[i]) begin
                if (cyc >= win_s[i] && cyc < win_e[i]) exp_pull = 1'b1;
                if ((cyc > win_s[i] - GUARD && cyc < win_s[i] + GUARD) ||
                    (cyc > win_e[i] - GUARD && cyc < win_e[i] + GUARD)) near = 1'b1;
            end
            if (!near) begin
                checks++;
                if (pull_low !== exp_pull) begin
                    failures++;
                    $display("FAIL R4/R7/R8 cycle %0d pull_low: actual=%0b expected=%0b",
                             cyc, pull_low, exp_pull);
                end
            end
        end
    end

    task automatic wait_us(input int us);
        repeat (us * TPU) @(negedge clk);
    endtask

    task automatic host_reset(input int us);
        int r;
        @(negedge clk);
        if (model_armed && model_idx < 64 && !ID[model_idx]) begin
            win_s.push_back(cyc + LAT);
            win_e.push_back(cyc + LAT + 30 * TPU);
        end
        host_low = 1'b1;
        wait_us(us);
        host_low = 1'b0;
        r = cyc;
        model_armed = 1'b0;
        if (us >= 480) begin
            win_s.push_back(r + LAT + 30 * TPU);
            win_e.push_back(r + LAT + 150 * TPU);
            model_fresh = 1'b1;
            wait_us(90);
            chk(pull_low === 1'b1, "R4", "mid presence pull_low", pull_low, 1);
            wait_us(110);
            chk(pull_low === 1'b0, "R4", "after presence pull_low", pull_low, 0);
        end else begin
            wait_us(200);
        end
    endtask

    task automatic host_write_bit(input bit b);
        @(negedge clk);
        host_low = 1'b1;
        wait_us(b ? 5 : 70);
        host_low = 1'b0;
        wait_us(b ? 70 : 5);
    endtask

    task automatic host_write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) host_write_bit(v[i]);
        if (model_fresh) begin
            model_armed = (v == 8'h33);
            model_idx = 0;
            model_fresh = 1'b0;
        end
    endtask

    task automatic host_read(input string req);
        bit exp_b;
        bit got;
        int idx;
        exp_b = model_armed ? ID[model_idx] : 1'b1;
        idx = model_idx;
        @(negedge clk);
        if (!exp_b) begin
            win_s.push_back(cyc + LAT);
            win_e.push_back(cyc + LAT + 30 * TPU);
        end
        host_low = 1'b1;
        wait_us(2);
        host_low = 1'b0;
        wait_us(11);
        got = bus;
        wait_us(59);
        chk(got == exp_b, req, $sformatf("read slot (bit %0d)", idx), got, exp_b);
        if (model_armed) begin
            model_idx++;
            if (model_idx == 64) model_armed = 1'b0;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        chk(pull_low === 1'b0, "R1", "pull_low in reset", pull_low, 0);
        rst_n = 1'b1;
        wait_us(20);
        chk(pull_low === 1'b0, "R1", "pull_low after reset", pull_low, 0);

        // R3: short low pulse is not a reset; block stays idle
        host_reset(400);
        host_write_byte(8'h33);
        host_read("R3");
        host_read("R3");

        // R4 presence, R5 decode, R6 full read-out, R9 idle afterwards
        host_reset(500);
        host_write_byte(8'h33);
        for (int i = 0; i < 64; i++) host_read("R6");
        for (int i = 0; i < 3; i++) host_read("R9");

        // R5 bit order: 0xCC would equal 0x33 if taken MSB first; R8 no response
        host_reset(500);
        host_write_byte(8'hCC);
        for (int i = 0; i < 8; i++) host_read("R5/R8");

        // R5 single written-1 vs written-0 decode: 0x32 is not the read command
        host_reset(500);
        host_write_byte(8'h32);
        for (int i = 0; i < 8; i++) host_read("R5/R8");

        // R2: reset in the middle of a read-out restarts the exchange
        host_reset(500);
        host_write_byte(8'h33);
        for (int i = 0; i < 10; i++) host_read("R6");
        host_reset(500);
        host_write_byte(8'h33);
        for (int i = 0; i < 64; i++) host_read("R2/R6");
        host_read("R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule